// File: doc/BRIEF.md
# Breakpoint Trigger Unit

This block watches the instruction-address stream and the operand bus of a processor and raises breakpoint triggers. Four instruction-address comparators and one operand-address window are the match sources. The window has a low and a high bound, its test can be inverted, and it can be narrowed by a data comparison whose mask drops chosen bits. Each source is enabled on its own and assigned to a first or a second trigger level.

In single-level use, any enabled match fires the trigger. In two-level use, a first-level match arms the unit, and only a later second-level match fires it. A fire produces one configured action: a one-clock halt request, a one-clock debug interrupt, or a status-only record. In trace mode the first-level match starts the trace-enable output and the second-level match stops it. After a fire the unit stays locked until the configuration register is written again.

The CPU side can only write registers. The debug side can write every register and can read the configuration/status register, with the data appearing one cycle after the request.

Top module: `brk_trig_unit`

## Requirements
- R1: After synchronous reset every source is disabled, all action outputs are low, and a configuration read returns 0x001C0000: the sequencer state is idle (bits 17:16 = 0) and the cause field is "none" (bits 20:18 = 7).
- R2: Registers are at addresses 0 (configuration), 1..4 (instruction comparators 0..3), 5 (window low), 6 (window high), 7 (data value) and 8 (data mask). Comparator n matches when its enable (configuration bit n) is set, pc_valid is high and pc equals its register. Register bit 0 is always stored as 0.
- R3: The operand source is enabled by configuration bit 4. Without inversion it matches when low <= opnd_addr <= high, both bounds included. When configuration bit 6 is set it matches when the address lies outside that range.
- R4: When configuration bit 5 is set, an operand match also needs opnd_data to equal the data value on every bit where the mask bit is 0. Mask bits at 1 are ignored.
- R5: In single-level mode (bit 7 = 0), any enabled match in the idle state fires. The cause field records the lowest-numbered matching source: 0..3 for the comparators and 4 for the operand window.
- R6: In two-level mode (bit 7 = 1), a source whose bit in field 14:10 (bit 10+source) is set belongs to level 1, and the other sources belong to level 2. A level-1 match in idle moves the state to armed (1). A level-2 match while armed fires. In idle, a level-2 match, including one in the same cycle as a level-1 match, does not fire.
- R7: Action field 9:8 = 0 raises halt_req and 1 raises dbg_irq. The pulse lasts exactly one clock, in the cycle after the matching observation. The state becomes fired (2), and no further pulse occurs until the configuration register is written.
- R8: With action 2 (trace), a level-1 match in idle raises trace_on and arms the unit. A level-2 match while armed drops trace_on and fires. Neither step raises halt_req or dbg_irq.
- R9: Any write to the configuration register returns the state to idle, sets the cause to 7 and clears trace_on. Writes to other registers leave the state unchanged.
- R10: Debug reads of address 0 return the configuration in bits 14:0 together with the status, one cycle after dbg_rd_en. Reads of any other address return 0. Reserved configuration bits (31:15) are stored as zero. CPU and debug writes have the same effect.
- R11: Action 3 records the fire in the state and cause fields and drives no halt, interrupt or trace output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_wr_addr | input | 4 | CPU register write address |
| cpu_wr_data | input | 32 | CPU register write data |
| dbg_wr_en | input | 1 | Debug-port write strobe (wins over a CPU write) |
| dbg_rd_en | input | 1 | Debug-port read strobe |
| dbg_addr | input | 4 | Debug-port register address |
| dbg_wr_data | input | 32 | Debug-port write data |
| dbg_rd_data | output | 32 | Debug-port read data, valid the cycle after dbg_rd_en |
| pc_valid | input | 1 | Instruction address valid |
| pc | input | 32 | Instruction address |
| opnd_valid | input | 1 | Operand access valid |
| opnd_addr | input | 32 | Operand address |
| opnd_data | input | 32 | Operand data |
| halt_req | output | 1 | One-clock halt request |
| dbg_irq | output | 1 | One-clock debug interrupt request |
| trace_on | output | 1 | Trace recording enable |

## Verification
The hardest case to reach is a second-level fire that depends on history. The unit must first be armed by one source, must ignore a second-level match that arrives in the same cycle as the arming match, and only then fire on a later match. The bench drives these as explicit ordered observation sequences and reads the state field after every step. The locking after a fire is reached by repeating a matching observation and by writing a non-configuration register, and only a configuration write is allowed to re-arm the unit. The window and mask behaviour is swept across both bounds, one step on each side, in both polarities.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NUM_PC   = 4;
  localparam int NUM_SRC  = NUM_PC + 1;
  localparam int CAUSE_W  = $clog2(NUM_SRC + 1);
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = '1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } brk_state_e;

  typedef enum logic [1:0] {
    ACT_HALT  = 2'd0,
    ACT_IRQ   = 2'd1,
    ACT_TRACE = 2'd2,
    ACT_NONE  = 2'd3
  } brk_act_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] lvl1;
    brk_act_e           act;
    logic               two_lvl;
    logic               inv;
    logic               dat_en;
    logic               op_en;
    logic [NUM_PC-1:0]  pc_en;
  } brk_cfg_t;

  localparam int CFG_W = $bits(brk_cfg_t);
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int RA = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_wr_en,
  input  logic [RA-1:0]              cpu_wr_addr,
  input  logic [AW-1:0]              cpu_wr_data,
  input  logic                       dbg_wr_en,
  input  logic [RA-1:0]              dbg_addr,
  input  logic [AW-1:0]              dbg_wr_data,
  output brk_cfg_t                   cfg,
  output logic [NUM_PC-1:0][AW-1:0]  pc_ref,
  output logic [AW-1:0]              win_lo,
  output logic [AW-1:0]              win_hi,
  output logic [AW-1:0]              dat_val,
  output logic [AW-1:0]              dat_msk,
  output logic                       cfg_wr
);
  localparam int A_CFG = 0;
  localparam int A_PC0 = 1;
  localparam int A_LO  = A_PC0 + NUM_PC;
  localparam int A_HI  = A_LO + 1;
  localparam int A_DV  = A_HI + 1;
  localparam int A_DM  = A_DV + 1;

  logic          wr;
  logic [RA-1:0] wa;
  logic [AW-1:0] wd;

  // debug port has priority over a simultaneous CPU write
  always_comb begin
    wr = dbg_wr_en | cpu_wr_en;
    wa = dbg_wr_en ? dbg_addr    : cpu_wr_addr;
    wd = dbg_wr_en ? dbg_wr_data : cpu_wr_data;
  end

  assign cfg_wr = wr && (wa == RA'(A_CFG));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      win_lo  <= '0;
      win_hi  <= '0;
      dat_val <= '0;
      dat_msk <= '0;
    end else if (wr) begin
      if (wa == RA'(A_CFG)) cfg     <= brk_cfg_t'(wd[CFG_W-1:0]);
      if (wa == RA'(A_LO))  win_lo  <= wd;
      if (wa == RA'(A_HI))  win_hi  <= wd;
      if (wa == RA'(A_DV))  dat_val <= wd;
      if (wa == RA'(A_DM))  dat_msk <= wd;
    end
  end

  for (genvar n = 0; n < NUM_PC; n++) begin : g_pcreg
    always_ff @(posedge clk) begin
      if (rst)
        pc_ref[n] <= '0;
      else if (wr && wa == RA'(A_PC0 + n))
        pc_ref[n] <= {wd[AW-1:1], 1'b0};
    end
  end
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [NUM_PC-1:0]          pc_en,
  input  logic                       op_en,
  input  logic                       dat_en,
  input  logic                       inv,
  input  logic [NUM_PC-1:0][AW-1:0]  pc_ref,
  input  logic [AW-1:0]              win_lo,
  input  logic [AW-1:0]              win_hi,
  input  logic [AW-1:0]              dat_val,
  input  logic [AW-1:0]              dat_msk,
  input  logic                       pc_valid,
  input  logic [AW-1:0]              pc,
  input  logic                       opnd_valid,
  input  logic [AW-1:0]              opnd_addr,
  input  logic [AW-1:0]              opnd_data,
  output logic [NUM_SRC-1:0]         hit
);
  for (genvar n = 0; n < NUM_PC; n++) begin : g_pccmp
    assign hit[n] = pc_en[n] && pc_valid && (pc == pc_ref[n]);
  end

  logic in_win, dat_ok;
  always_comb begin
    in_win = (opnd_addr >= win_lo) && (opnd_addr <= win_hi);
    dat_ok = !dat_en || (((opnd_data ^ dat_val) & ~dat_msk) == '0);
  end

  assign hit[NUM_PC] = op_en && opnd_valid && (in_win ^ inv) && dat_ok;
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic                two_lvl,
  input  brk_act_e            act,
  input  logic [NUM_SRC-1:0]  lvl1,
  input  logic [NUM_SRC-1:0]  hit,
  output brk_state_e          state,
  output logic [CAUSE_W-1:0]  cause,
  output logic                halt_req,
  output logic                dbg_irq,
  output logic                trace_on
);
  function automatic logic [CAUSE_W-1:0] first_src(input logic [NUM_SRC-1:0] v);
    logic [CAUSE_W-1:0] r;
    r = CAUSE_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) r = CAUSE_W'(i);
    return r;
  endfunction

  logic [NUM_SRC-1:0] l1_hit, l2_hit;
  logic               staged;

  always_comb begin
    l1_hit = hit & lvl1;
    l2_hit = hit & ~lvl1;
    staged = two_lvl || (act == ACT_TRACE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cause    <= CAUSE_NONE;
      halt_req <= 1'b0;
      dbg_irq  <= 1'b0;
      trace_on <= 1'b0;
    end else begin
      halt_req <= 1'b0;
      dbg_irq  <= 1'b0;
      if (cfg_wr) begin
        state    <= ST_IDLE;
        cause    <= CAUSE_NONE;
        trace_on <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (!staged && |hit) begin
              state    <= ST_FIRED;
              cause    <= first_src(hit);
              halt_req <= (act == ACT_HALT);
              dbg_irq  <= (act == ACT_IRQ);
            end else if (staged && |l1_hit) begin
              state <= ST_ARMED;
              if (act == ACT_TRACE) trace_on <= 1'b1;
            end
          end
          ST_ARMED: begin
            if (|l2_hit) begin
              state    <= ST_FIRED;
              cause    <= first_src(l2_hit);
              halt_req <= (act == ACT_HALT);
              dbg_irq  <= (act == ACT_IRQ);
              trace_on <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/brk_trig_unit.sv
module brk_trig_unit
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int RA = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr_en,
  input  logic [RA-1:0] cpu_wr_addr,
  input  logic [AW-1:0] cpu_wr_data,
  input  logic          dbg_wr_en,
  input  logic          dbg_rd_en,
  input  logic [RA-1:0] dbg_addr,
  input  logic [AW-1:0] dbg_wr_data,
  output logic [AW-1:0] dbg_rd_data,
  input  logic          pc_valid,
  input  logic [AW-1:0] pc,
  input  logic          opnd_valid,
  input  logic [AW-1:0] opnd_addr,
  input  logic [AW-1:0] opnd_data,
  output logic          halt_req,
  output logic          dbg_irq,
  output logic          trace_on
);
  localparam int ST_LSB = 16;
  localparam int CS_LSB = ST_LSB + 2;

  brk_cfg_t                  cfg;
  logic [NUM_PC-1:0][AW-1:0] pc_ref;
  logic [AW-1:0]             win_lo, win_hi, dat_val, dat_msk;
  logic                      cfg_wr;
  logic [NUM_SRC-1:0]        hit;
  brk_state_e                state;
  logic [CAUSE_W-1:0]        cause;

  brk_regs #(.AW(AW), .RA(RA)) u_regs (
    .clk(clk), .rst(rst),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .dbg_wr_en(dbg_wr_en), .dbg_addr(dbg_addr), .dbg_wr_data(dbg_wr_data),
    .cfg(cfg), .pc_ref(pc_ref), .win_lo(win_lo), .win_hi(win_hi),
    .dat_val(dat_val), .dat_msk(dat_msk), .cfg_wr(cfg_wr)
  );

  brk_match #(.AW(AW)) u_match (
    .pc_en(cfg.pc_en), .op_en(cfg.op_en), .dat_en(cfg.dat_en), .inv(cfg.inv),
    .pc_ref(pc_ref), .win_lo(win_lo), .win_hi(win_hi),
    .dat_val(dat_val), .dat_msk(dat_msk),
    .pc_valid(pc_valid), .pc(pc),
    .opnd_valid(opnd_valid), .opnd_addr(opnd_addr), .opnd_data(opnd_data),
    .hit(hit)
  );

  brk_seq u_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
    .two_lvl(cfg.two_lvl), .act(cfg.act), .lvl1(cfg.lvl1), .hit(hit),
    .state(state), .cause(cause),
    .halt_req(halt_req), .dbg_irq(dbg_irq), .trace_on(trace_on)
  );

  logic [AW-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    rd_word[CFG_W-1:0]            = cfg;
    rd_word[ST_LSB+1:ST_LSB]      = state;
    rd_word[CS_LSB+CAUSE_W-1:CS_LSB] = cause;
  end

  always_ff @(posedge clk) begin
    if (rst)
      dbg_rd_data <= '0;
    else if (dbg_rd_en && dbg_addr == '0)
      dbg_rd_data <= rd_word;
    else
      dbg_rd_data <= '0;
  end
endmodule

// File: rtl/brk_trig_unit_chk.sv
module brk_trig_unit_chk
  import brk_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr,
  input brk_act_e   act,
  input brk_state_e state,
  input logic       halt_req,
  input logic       dbg_irq,
  input logic       trace_on
);
  logic locked;
  always_ff @(posedge clk) begin
    if (rst)                      locked <= 1'b0;
    else if (cfg_wr)              locked <= 1'b0;
    else if (halt_req || dbg_irq) locked <= 1'b1;
  end

  assert_halt_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !halt_req);
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    dbg_irq |=> !dbg_irq);
  assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
    locked |-> !(halt_req || dbg_irq));
  assert_halt_action_R11: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> $past(act) == ACT_HALT);
  assert_irq_action_R11: assert property (@(posedge clk) disable iff (rst)
    dbg_irq |-> $past(act) == ACT_IRQ);
  assert_trace_mode_R8: assert property (@(posedge clk) disable iff (rst)
    trace_on |-> act == ACT_TRACE);
  assert_rearm_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (state == ST_IDLE) && !halt_req && !dbg_irq && !trace_on);
endmodule

bind brk_trig_unit brk_trig_unit_chk i_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .act(cfg.act), .state(state),
  .halt_req(halt_req), .dbg_irq(dbg_irq), .trace_on(trace_on)
);

// File: tb/test_brk_trig_unit.sv
module test_brk_trig_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr_en = 1'b0;
  logic [3:0]  cpu_wr_addr = '0;
  logic [31:0] cpu_wr_data = '0;
  logic        dbg_wr_en = 1'b0;
  logic        dbg_rd_en = 1'b0;
  logic [3:0]  dbg_addr = '0;
  logic [31:0] dbg_wr_data = '0;
  logic [31:0] dbg_rd_data;
  logic        pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic        opnd_valid = 1'b0;
  logic [31:0] opnd_addr = '0;
  logic [31:0] opnd_data = '0;
  logic        halt_req, dbg_irq, trace_on;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  brk_trig_unit i_brk_trig_unit (.*);

  localparam logic [31:0] OP = 32'h10, DAT = 32'h20, INV = 32'h40, TWO = 32'h80;
  localparam logic [31:0] A_IRQ = 32'h100, A_TRC = 32'h200, A_NONE = 32'h300;

  function automatic logic [31:0] stat(input logic [31:0] c, input logic [1:0] s,
                                       input logic [2:0] k);
    return (c & 32'h7FFF) | (32'(s) << 16) | (32'(k) << 18);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit use_dbg, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    if (use_dbg) begin dbg_wr_en = 1; dbg_addr = a; dbg_wr_data = d; end
    else begin cpu_wr_en = 1; cpu_wr_addr = a; cpu_wr_data = d; end
    @(negedge clk);
    dbg_wr_en = 0; cpu_wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    dbg_rd_en = 1; dbg_addr = a;
    @(negedge clk);
    dbg_rd_en = 0;
    d = dbg_rd_data;
  endtask

  // one observation cycle; returns the outputs seen one cycle later
  task automatic see(input bit pv, input logic [31:0] p, input bit ov,
                     input logic [31:0] oa, input logic [31:0] od,
                     output logic [2:0] o);
    @(negedge clk);
    pc_valid = pv; pc = p; opnd_valid = ov; opnd_addr = oa; opnd_data = od;
    @(negedge clk);
    pc_valid = 0; opnd_valid = 0;
    o = {trace_on, dbg_irq, halt_req};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [2:0]  o;
    logic [31:0] cfg;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(4'd0, r);
    chk("R1 status", r, 32'h001C0000);
    chk("R1 outputs", {29'd0, trace_on, dbg_irq, halt_req}, 0);
    see(1, 32'h0, 1, 32'h0, 32'h0, o);
    chk("R1 disabled no fire", o, 0);

    // R2 comparator sweep, bit 0 written as 1 must be stored as 0
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 4; k++)
        wr(k[0], 4'(1 + k), 32'h1000 + 32'(k) * 32'h40 + 1);
      for (int k = 0; k < 4; k++) begin
        wr(n[0], 4'd0, 32'(1) << n);
        see(1, 32'h1000 + 32'(k) * 32'h40, 0, 0, 0, o);
        chk($sformatf("R2 pc%0d addr%0d", n, k), o, (k == n) ? 3'b001 : 3'b000);
      end
      wr(1, 4'd0, 32'(1) << n);
      see(1, 32'h1000 + 32'(n) * 32'h40 + 1, 0, 0, 0, o);
      chk("R2 odd pc no match", o, 0);
    end

    // R3 window sweep, both polarities, IRQ action
    wr(0, 4'd5, 32'h200);
    wr(1, 4'd6, 32'h210);
    for (int inv = 0; inv < 2; inv++)
      for (int a = 32'h1F8; a <= 32'h218; a += 4) begin
        cfg = OP | A_IRQ | (inv ? INV : 0);
        wr(1, 4'd0, cfg);
        see(0, 0, 1, 32'(a), 0, o);
        chk($sformatf("R3 inv%0d a%h", inv, a), o,
            (((a >= 32'h200) && (a <= 32'h210)) ^ (inv != 0)) ? 3'b010 : 3'b000);
      end

    // R4 masked data
    wr(0, 4'd5, 32'h0);
    wr(0, 4'd6, 32'hFFFFFFFF);
    wr(0, 4'd7, 32'hA5A500FF);
    for (int m = 0; m < 3; m++) begin
      logic [31:0] msk;
      msk = (m == 0) ? 32'h0 : (m == 1) ? 32'h0000FFFF : 32'hFFFFFFFF;
      wr(1, 4'd8, msk);
      for (int d = 0; d < 4; d++) begin
        logic [31:0] dv;
        dv = (d == 0) ? 32'hA5A500FF : (d == 1) ? 32'hA5A500FE :
             (d == 2) ? 32'hA5A400FF : 32'h5A5AFF00;
        wr(0, 4'd0, OP | DAT);
        see(0, 0, 1, 32'h40, dv, o);
        chk($sformatf("R4 m%0d d%0d", m, d), o,
            (((dv ^ 32'hA5A500FF) & ~msk) == 0) ? 3'b001 : 3'b000);
      end
    end

    // R5 priority of cause
    for (int k = 0; k < 4; k++) wr(0, 4'(1 + k), 32'h3000);
    wr(0, 4'd0, 32'hF | OP);
    see(1, 32'h3000, 1, 32'h3000, 0, o);
    rd(4'd0, r);
    chk("R5 cause lowest all", r, stat(32'hF | OP, 2, 0));
    wr(0, 4'd0, 32'hC);
    see(1, 32'h3000, 0, 0, 0, o);
    rd(4'd0, r);
    chk("R5 cause 2", r, stat(32'hC, 2, 2));
    wr(0, 4'd0, 32'h8 | OP);
    see(1, 32'h3004, 1, 32'h50, 0, o);
    rd(4'd0, r);
    chk("R5 cause operand", r, stat(32'h8 | OP, 2, 4));

    // R6 two-level sequencing
    wr(1, 4'd1, 32'h4000);
    wr(1, 4'd2, 32'h4100);
    cfg = 32'h3 | TWO | (32'h1 << 10);
    wr(0, 4'd0, cfg);
    see(1, 32'h4100, 0, 0, 0, o);
    rd(4'd0, r);
    chk("R6 level2 first no fire", {o, r[28:0]}, {3'b000, stat(cfg, 0, 7)});
    see(1, 32'h4000, 0, 0, 0, o);
    rd(4'd0, r);
    chk("R6 armed", {o, r[28:0]}, {3'b000, stat(cfg, 1, 7)});
    see(1, 32'h4000, 0, 0, 0, o);
    chk("R6 level1 again no fire", o, 0);
    see(1, 32'h4100, 0, 0, 0, o);
    chk("R6 level2 fires", o, 3'b001);
    rd(4'd0, r);
    chk("R6 fired cause 1", r, stat(cfg, 2, 1));
    cfg = 32'h1 | OP | TWO | (32'h1 << 10);
    wr(1, 4'd0, cfg);
    see(1, 32'h4000, 1, 32'h5000, 0, o);
    rd(4'd0, r);
    chk("R6 same-cycle arms only", {o, r[28:0]}, {3'b000, stat(cfg, 1, 7)});
    see(0, 0, 1, 32'h5000, 0, o);
    chk("R6 operand fires", o, 3'b001);
    rd(4'd0, r);
    chk("R6 cause 4", r, stat(cfg, 2, 4));

    // R7 one-clock pulse and lock; R9 re-arm only by configuration write
    wr(0, 4'd0, 32'h1);
    see(1, 32'h4000, 0, 0, 0, o);
    chk("R7 fire", o, 3'b001);
    @(negedge clk);
    chk("R7 one clock", {29'd0, trace_on, dbg_irq, halt_req}, 0);
    see(1, 32'h4000, 0, 0, 0, o);
    chk("R7 locked", o, 0);
    wr(0, 4'd1, 32'h4000);
    see(1, 32'h4000, 0, 0, 0, o);
    rd(4'd0, r);
    chk("R9 other write keeps lock", {o, r[28:0]}, {3'b000, stat(32'h1, 2, 0)});
    wr(1, 4'd0, 32'h1);
    rd(4'd0, r);
    chk("R9 cfg write clears status", r, stat(32'h1, 0, 7));
    see(1, 32'h4000, 0, 0, 0, o);
    chk("R9 rearmed fires", o, 3'b001);

    // R8 trace start and stop
    cfg = 32'h3 | A_TRC | (32'h1 << 10);
    wr(0, 4'd0, cfg);
    see(1, 32'h4100, 0, 0, 0, o);
    chk("R8 stop before start", o, 0);
    see(1, 32'h4000, 0, 0, 0, o);
    chk("R8 start", o, 3'b100);
    @(negedge clk);
    chk("R8 stays on", {31'd0, trace_on}, 1);
    see(1, 32'h4100, 0, 0, 0, o);
    chk("R8 stop", o, 0);
    rd(4'd0, r);
    chk("R8 fired cause 1", r, stat(cfg, 2, 1));
    see(1, 32'h4000, 0, 0, 0, o);
    chk("R8 no restart", o, 0);
    wr(0, 4'd0, cfg);
    see(1, 32'h4000, 0, 0, 0, o);
    chk("R8 restart after rearm", o, 3'b100);
    wr(1, 4'd0, cfg);
    chk("R9 cfg write stops trace", {31'd0, trace_on}, 0);

    // R11 status-only action
    wr(0, 4'd0, 32'h1 | A_NONE);
    see(1, 32'h4000, 0, 0, 0, o);
    chk("R11 no output", o, 0);
    rd(4'd0, r);
    chk("R11 status", r, stat(32'h1 | A_NONE, 2, 0));

    // R10 reserved bits, CPU write, other-address read
    wr(0, 4'd0, 32'hFFFFFFFF);
    rd(4'd0, r);
    chk("R10 reserved dropped", r, stat(32'h7FFF, 0, 7));
    rd(4'd1, r);
    chk("R10 other address reads zero", r, 0);
    wr(0, 4'd0, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule